// File: doc/BRIEF.md
# Redundant Memory Access Filter

This block sits between a requester and a single-port synchronous RAM, which is modelled as a small internal array. Each cycle the requester presents a read strobe, a write strobe, an address, write data and a flag that says whether the result of a read will be used. The filter decides in the same cycle whether the RAM strobe is actually raised. The goal is to skip every access that could not change what anyone sees.

A read whose result nobody will use is withheld. A read of the address fetched by the last forwarded read is also withheld when no write has happened since. A write that repeats the last forwarded write is dropped. Read data comes back one cycle after the request from a holding register. That register is reloaded only by forwarded reads, so a withheld read returns the value already held.

Four counters tally forwarded and withheld reads and writes.

Top module: `rdf_filter`

## Requirements
- R1: A read (read strobe high, write strobe low) with the observe flag low never raises `mem_rd`. It is counted as a dropped read, and `rsp_data` keeps its value.
- R2: An observed read to the address of the most recent forwarded read is dropped when no write strobe has been seen since that read. `mem_rd` stays low and `rsp_data` keeps the held value.
- R3: Any write request, whether forwarded or dropped, clears the read history. The next observed read is therefore forwarded, including a read to the address just written.
- R4: A write is dropped (`mem_wr` low) when a previous forwarded write exists and both its address and its data equal the current ones. Otherwise the write is forwarded and updates the RAM.
- R5: Reset clears the read and write history, `rsp_data` and all counters to zero. The first observed read and the first write after reset are forwarded.
- R6: When read and write strobes are high together, only the write is handled. `mem_rd` stays low and the read is neither counted nor affects the history.
- R7: One cycle after a forwarded read, `rsp_data` equals the RAM word at that address, which reflects every forwarded write. `rsp_data` changes at no other time.
- R8: `cnt_rd_fwd`, `cnt_rd_drop`, `cnt_wr_fwd` and `cnt_wr_drop` each add one per matching event and wrap modulo 2^CW.
- R9: `mem_addr` and `mem_wdata` equal `req_addr` and `req_wdata` in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_obs | input | 1 | The result of this read will be consumed |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| mem_rd | output | 1 | Read strobe forwarded to the RAM |
| mem_wr | output | 1 | Write strobe forwarded to the RAM |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| rsp_data | output | DW | Read data returned to the requester |
| cnt_rd_fwd | output | CW | Forwarded read count |
| cnt_rd_drop | output | CW | Dropped read count |
| cnt_wr_fwd | output | CW | Forwarded write count |
| cnt_wr_drop | output | CW | Dropped write count |

## Verification
The RAM strobes, `mem_addr` and `mem_wdata` are combinational, so they are due in the same cycle as the request. The bench samples them one nanosecond after it drives the inputs on the falling edge. `rsp_data` and the counters are due one rising edge after the request. The bench therefore compares them at the next falling edge against a model whose state it advances only after that cycle's strobe checks. Every cycle compares all outputs, so a response that is late, early or reloaded by a dropped read shows up as a mismatch.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int NUM_CNT = 4;

  typedef enum int {
    CNT_RD_FWD  = 0,
    CNT_RD_DROP = 1,
    CNT_WR_FWD  = 2,
    CNT_WR_DROP = 3
  } cnt_sel_e;

  // a read competes only when no write is present (write wins)
  function automatic logic read_only(input logic rd, input logic wr);
    return rd & ~wr;
  endfunction

  // a read reaches the RAM when it is observed and not a repeat
  function automatic logic read_passes(input logic rd_only, input logic obs,
                                       input logic repeat_hit);
    return rd_only & obs & ~repeat_hit;
  endfunction

  // a write reaches the RAM unless it repeats the last forwarded one
  function automatic logic write_passes(input logic wr, input logic repeat_hit);
    return wr & ~repeat_hit;
  endfunction
endpackage

// File: rtl/rdf_track.sv
module rdf_track #(
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          kill,
  input  logic [KW-1:0] key,
  output logic          hit
);
  logic          vld_q;
  logic [KW-1:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      key_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      key_q <= key;
    end else if (kill) begin
      vld_q <= 1'b0;
    end
  end

  assign hit = vld_q && (key_q == key);
endmodule

// File: rtl/rdf_ram.sv
module rdf_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      if (re) rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rdf_cnt.sv
module rdf_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rdf_filter.sv
module rdf_filter
  import rdf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic          req_obs,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rsp_data,
  output logic [CW-1:0] cnt_rd_fwd,
  output logic [CW-1:0] cnt_rd_drop,
  output logic [CW-1:0] cnt_wr_fwd,
  output logic [CW-1:0] cnt_wr_drop
);
  localparam int WKW = AW + DW;

  // named internal events
  logic rd_only;
  logic rd_hit;
  logic wr_hit;
  logic rd_fwd;
  logic rd_drop;
  logic wr_fwd;
  logic wr_drop;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CW-1:0]      cnt_bus [NUM_CNT];

  assign rd_only = read_only(req_rd, req_wr);
  assign rd_fwd  = read_passes(rd_only, req_obs, rd_hit);
  assign rd_drop = rd_only & ~rd_fwd;
  assign wr_fwd  = write_passes(req_wr, wr_hit);
  assign wr_drop = req_wr & ~wr_fwd;

  // read stability: address of last forwarded read, cleared by any write
  rdf_track #(.KW(AW)) u_rd_track (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_fwd),
    .kill  (req_wr),
    .key   (req_addr),
    .hit   (rd_hit)
  );

  // write stability: address and data of last forwarded write
  rdf_track #(.KW(WKW)) u_wr_track (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_fwd),
    .kill  (1'b0),
    .key   ({req_addr, req_wdata}),
    .hit   (wr_hit)
  );

  rdf_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fwd),
    .re    (rd_fwd),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (rsp_data)
  );

  assign cnt_inc[CNT_RD_FWD]  = rd_fwd;
  assign cnt_inc[CNT_RD_DROP] = rd_drop;
  assign cnt_inc[CNT_WR_FWD]  = wr_fwd;
  assign cnt_inc[CNT_WR_DROP] = wr_drop;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rdf_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_bus[g])
    );
  end

  assign cnt_rd_fwd  = cnt_bus[CNT_RD_FWD];
  assign cnt_rd_drop = cnt_bus[CNT_RD_DROP];
  assign cnt_wr_fwd  = cnt_bus[CNT_WR_FWD];
  assign cnt_wr_drop = cnt_bus[CNT_WR_DROP];

  assign mem_rd    = rd_fwd;
  assign mem_wr    = wr_fwd;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
endmodule

// File: rtl/rdf_chk.sv
module rdf_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_rd,
  input logic          req_wr,
  input logic          req_obs,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] rsp_data,
  input logic [CW-1:0] cnt_rd_fwd,
  input logic [CW-1:0] cnt_wr_fwd
);
  a_r1_unobserved_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && !req_obs) |-> !mem_rd);

  a_r2_repeat_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && req_obs && $past(mem_rd) && req_addr == $past(req_addr))
      |-> !mem_rd);

  a_r3_read_after_write_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_wr) && req_rd && !req_wr && req_obs) |-> mem_rd);

  a_r4_repeat_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && $past(mem_wr) && req_addr == $past(req_addr)
      && req_wdata == $past(req_wdata)) |-> !mem_wr);

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |-> !mem_rd);

  a_r7_held_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mem_rd) |-> $stable(rsp_data));

  a_r8_rd_fwd_count: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_fwd == CW'($past(cnt_rd_fwd) + CW'($past(mem_rd))));

  a_r8_wr_fwd_count: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_fwd == CW'($past(cnt_wr_fwd) + CW'($past(mem_wr))));
endmodule

bind rdf_filter rdf_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_rd     (req_rd),
  .req_wr     (req_wr),
  .req_obs    (req_obs),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .rsp_data   (rsp_data),
  .cnt_rd_fwd (cnt_rd_fwd),
  .cnt_wr_fwd (cnt_wr_fwd)
);

// File: tb/test_rdf_filter.sv
`timescale 1ns/1ps
module test_rdf_filter;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int CMASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_rd = 1'b0, req_wr = 1'b0, req_obs = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rsp_data;
  logic [CW-1:0] cnt_rd_fwd, cnt_rd_drop, cnt_wr_fwd, cnt_wr_drop;

  always #2.5 clk = ~clk;

  rdf_filter #(.AW(AW), .DW(DW), .CW(CW)) i_rdf_filter (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_obs(req_obs),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rsp_data(rsp_data),
    .cnt_rd_fwd(cnt_rd_fwd), .cnt_rd_drop(cnt_rd_drop),
    .cnt_wr_fwd(cnt_wr_fwd), .cnt_wr_drop(cnt_wr_drop)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference
  int m_mem [int];
  int m_rsp = 0;
  bit m_rvld = 0;
  int m_raddr = 0;
  bit m_wvld = 0;
  int m_waddr = 0, m_wdat = 0;
  int c_rf = 0, c_rd = 0, c_wf = 0, c_wd = 0;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    cmp(tag, "rsp_data", int'(rsp_data), m_rsp);
    cmp("R8", "cnt_rd_fwd", int'(cnt_rd_fwd), c_rf & CMASK);
    cmp("R8", "cnt_rd_drop", int'(cnt_rd_drop), c_rd & CMASK);
    cmp("R8", "cnt_wr_fwd", int'(cnt_wr_fwd), c_wf & CMASK);
    cmp("R8", "cnt_wr_drop", int'(cnt_wr_drop), c_wd & CMASK);
  endtask

  task automatic step(input bit rd, input bit wr, input int addr, input int data,
                      input bit obs, input string tag);
    bit e_rd, e_wr;
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_addr = AW'(addr); req_wdata = DW'(data); req_obs = obs;
    #1;
    // registered results of the previous cycle
    check_state(tag);
    e_wr = wr && !(m_wvld && addr == m_waddr && data == m_wdat);
    e_rd = !wr && rd && obs && !(m_rvld && addr == m_raddr);
    cmp(tag, "mem_wr", int'(mem_wr), int'(e_wr));
    cmp(tag, "mem_rd", int'(mem_rd), int'(e_rd));
    cmp("R9", "mem_addr", int'(mem_addr), addr);
    cmp("R9", "mem_wdata", int'(mem_wdata), data);
    if (wr) begin
      if (e_wr) begin
        m_mem[addr] = data; m_wvld = 1; m_waddr = addr; m_wdat = data; c_wf++;
      end else c_wd++;
      m_rvld = 0;
    end else if (rd) begin
      if (e_rd) begin
        m_rsp = m_mem.exists(addr) ? m_mem[addr] : 0;
        m_rvld = 1; m_raddr = addr; c_rf++;
      end else c_rd++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    #1;
    check_state("R5");
    @(negedge clk);
    rst_n = 1'b1;

    // R5: first write and first read forwarded
    step(0, 1, 3, 8'h5A, 0, "R5");
    // R4: identical write dropped, then variants forwarded
    step(0, 1, 3, 8'h5A, 0, "R4");
    step(0, 1, 3, 8'h5B, 0, "R4");
    step(0, 1, 7, 8'h5B, 0, "R4");
    step(0, 1, 7, 8'h5B, 0, "R4");
    step(1, 0, 3, 0, 1, "R5");
    // R2: repeat reads dropped, data held
    step(1, 0, 3, 0, 1, "R2");
    step(1, 0, 3, 0, 1, "R2");
    // R1: unobserved reads withheld, even to a new address
    step(1, 0, 7, 0, 0, "R1");
    step(1, 0, 3, 0, 0, "R1");
    step(1, 0, 7, 0, 1, "R7");
    // R3: dropped write still clears read history
    step(0, 1, 7, 8'h5B, 0, "R3");
    step(1, 0, 7, 0, 1, "R3");
    step(0, 1, 7, 8'hC3, 0, "R3");
    step(1, 0, 7, 0, 1, "R3");
    // R6: simultaneous read and write
    step(1, 1, 2, 8'h11, 1, "R6");
    step(1, 1, 2, 8'h11, 1, "R6");
    step(1, 0, 2, 0, 1, "R6");
    step(0, 0, 0, 0, 0, "R7");
    // mixed traffic on a small address set, counters wrap (R8)
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      int r;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      r = lfsr;
      step(r[0], r[1] & r[2], (r >> 3) & 3, (r >> 5) & 3, r[7] | r[8], "R7");
    end
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R8");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule